// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Prescaler

This block is a watchdog that runs on its own free-running clock, separate from the processor clock. A base counter sets a nominal timeout of `BASE_TICKS` watchdog ticks. A chain of prescaler stages can stretch that interval by a factor of 2^n, where n comes from a 3-bit select field. The stretch applies only when a routing bit assigns the prescaler to the watchdog. Software keeps the watchdog from expiring by pulsing a clear strobe, which returns both counters to zero.

When the watchdog expires it raises a one-tick pulse. If the processor is running, the pulse goes to the reset output. If a power-down flag says the processor is asleep, the pulse goes to the wakeup output instead. A static enable stops the watchdog completely: no count, no clear and no pulses. With a base interval of about 16 ms, the eight select settings cover about 16 ms to about 2 s.

Top module: `wdt_top`

## Requirements
- R1: While `rst_i` is high, and in the cycle after it falls, both `wdt_reset_o` and `wdt_wake_o` are 0, and both counters start from zero.
- R2: With `ps_assign_i`=1 and `ps_sel_i`=s, the first pulse after reset, clear or a previous timeout comes at the edge of the enabled tick numbered `BASE_TICKS`*2^s. It is visible in the following cycle (s=0 gives factor 1, s=7 gives 128).
- R3: With `ps_assign_i`=0, the timeout is `BASE_TICKS` enabled ticks, whatever `ps_sel_i` holds.
- R4: When `pd_i` is 0 at the timeout edge, `wdt_reset_o` is high for exactly one cycle and `wdt_wake_o` stays 0. The two outputs are never high together.
- R5: When `pd_i` is 1 at the timeout edge, `wdt_wake_o` is high for exactly one cycle and `wdt_reset_o` stays 0.
- R6: After a timeout both counters restart from zero, so with unchanged inputs the pulses repeat every `BASE_TICKS`*factor ticks.
- R7: An enabled tick with `clr_i`=1 sets both counters to zero and produces no pulse, even on the tick that would have expired.
- R8: While `en_i` is 0 the counters hold, `clr_i` has no effect and both outputs are 0. Counting resumes from the held value when `en_i` returns to 1.
- R9: If the select or assign inputs lower the factor to or below the number of base intervals already completed, the timeout fires at the next base-interval boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Watchdog tick clock from the dedicated oscillator |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Static watchdog enable; 0 freezes the block |
| clr_i | input | 1 | Clear strobe, resets both counters on the next enabled tick |
| ps_sel_i | input | PS_BITS | Prescaler select, factor 2^value when assigned |
| ps_assign_i | input | 1 | 1 routes the prescaler to the watchdog |
| pd_i | input | 1 | Processor power-down status |
| wdt_reset_o | output | 1 | One-tick reset pulse on timeout while running |
| wdt_wake_o | output | 1 | One-tick wakeup pulse on timeout while powered down |

## Verification
The bench builds the block with `BASE_TICKS`=5 and the default 3-bit select. That makes even the largest factor of 128 expire within 640 ticks, so every select value, repeated timeouts and the widest prescaler count can be reached in a short run. The small base interval also lets the bench place a clear strobe exactly on an expiring tick, and lower the select while several base intervals are already done.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Prescaler terminal value (factor - 1) for a select value and routing bit.
  function automatic int unsigned wdt_ps_limit(input int unsigned sel,
                                               input logic routed);
    if (routed) return (32'd1 << sel) - 32'd1;
    return 32'd0;
  endfunction

  typedef struct packed {
    logic to_reset;
    logic to_wake;
  } wdt_event_t;

endpackage

// File: rtl/wdt_base_counter.sv
module wdt_base_counter #(
  parameter int BASE_TICKS = 16000,
  localparam int BASE_W    = (BASE_TICKS > 2) ? $clog2(BASE_TICKS) : 1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic clr_i,
  output logic wrap_o
);

  logic [BASE_W-1:0] cnt_q;
  logic              at_end;

  assign at_end = (cnt_q == BASE_W'(BASE_TICKS - 1));
  assign wrap_o = en_i && !clr_i && at_end;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (clr_i || at_end) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_base_freeze_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(cnt_q));

  assert_base_clear_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && clr_i) |=> (cnt_q == '0));

  assert_base_range_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= BASE_W'(BASE_TICKS - 1));

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PS_BITS = 3,
  localparam int PRE_W  = (1 << PS_BITS) - 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             wrap_i,
  input  logic [PRE_W-1:0] limit_i,
  output logic             fire_o
);

  logic [PRE_W-1:0] pre_q;

  // Compare with >= so a factor lowered mid-count still fires at the next boundary.
  assign fire_o = wrap_i && (pre_q >= limit_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pre_q <= '0;
    end else if (en_i) begin
      if (clr_i || fire_o) pre_q <= '0;
      else if (wrap_i)     pre_q <= pre_q + 1'b1;
    end
  end

  assert_pre_restart_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    fire_o |=> (pre_q == '0));

  assert_pre_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (wrap_i && !fire_o) |=> (pre_q == $past(pre_q) + 1'b1));

  assert_pre_freeze_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(pre_q));

endmodule

// File: rtl/wdt_pulse_out.sv
module wdt_pulse_out
  import wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic fire_i,
  input  logic pd_i,
  output logic reset_o,
  output logic wake_o
);

  wdt_event_t ev_d, ev_q;

  always_comb begin
    ev_d.to_reset = fire_i && !pd_i;
    ev_d.to_wake  = fire_i && pd_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) ev_q <= '0;
    else       ev_q <= ev_d;
  end

  assign reset_o = ev_q.to_reset;
  assign wake_o  = ev_q.to_wake;

  assert_exclusive_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !(reset_o && wake_o));

  assert_reset_single_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    reset_o |=> !reset_o);

  assert_wake_single_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    wake_o |=> !wake_o);

endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int BASE_TICKS = 16000,
  parameter int PS_BITS    = 3,
  localparam int PRE_W     = (1 << PS_BITS) - 1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               en_i,
  input  logic               clr_i,
  input  logic [PS_BITS-1:0] ps_sel_i,
  input  logic               ps_assign_i,
  input  logic               pd_i,
  output logic               wdt_reset_o,
  output logic               wdt_wake_o
);

  logic             base_wrap;
  logic             timeout;
  logic [PRE_W-1:0] ps_limit;

  initial begin
    if (BASE_TICKS < 2) $error("BASE_TICKS must be at least 2");
  end

  assign ps_limit = PRE_W'(wdt_ps_limit(32'(ps_sel_i), ps_assign_i));

  wdt_base_counter #(.BASE_TICKS(BASE_TICKS)) u_base (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .clr_i  (clr_i),
    .wrap_o (base_wrap)
  );

  wdt_prescaler #(.PS_BITS(PS_BITS)) u_pre (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .clr_i   (clr_i),
    .wrap_i  (base_wrap),
    .limit_i (ps_limit),
    .fire_o  (timeout)
  );

  wdt_pulse_out u_out (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .fire_i  (timeout),
    .pd_i    (pd_i),
    .reset_o (wdt_reset_o),
    .wake_o  (wdt_wake_o)
  );

  assert_disabled_quiet_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> !(wdt_reset_o || wdt_wake_o));

  assert_clear_no_pulse_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && clr_i) |=> !(wdt_reset_o || wdt_wake_o));

  assert_wake_routing_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    wdt_wake_o |-> $past(pd_i));

endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;

  localparam int BASE    = 5;
  localparam int PS_BITS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, clr = 1'b0, ps_assign = 1'b0, pd = 1'b0;
  logic [PS_BITS-1:0] ps_sel = '0;
  logic wdt_reset, wdt_wake;

  int vectors = 0;
  int misses  = 0;
  int elapsed = 0;
  int n_reset = 0, n_wake = 0;
  logic exp_reset = 1'b0, exp_wake = 1'b0;
  string req = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_top #(.BASE_TICKS(BASE), .PS_BITS(PS_BITS)) dut (
    .clk_i       (clk),
    .rst_i       (rst),
    .en_i        (en),
    .clr_i       (clr),
    .ps_sel_i    (ps_sel),
    .ps_assign_i (ps_assign),
    .pd_i        (pd),
    .wdt_reset_o (wdt_reset),
    .wdt_wake_o  (wdt_wake)
  );

  // Behavioural reference: one elapsed-tick integer per requirement text.
  always @(posedge clk) begin
    int factor;
    factor = ps_assign ? (1 << ps_sel) : 1;
    exp_reset = 1'b0;
    exp_wake  = 1'b0;
    if (rst) begin
      elapsed = 0;
    end else if (en) begin
      if (clr) begin
        elapsed = 0;
      end else begin
        elapsed++;
        if ((elapsed % BASE == 0) && (elapsed / BASE >= factor)) begin
          elapsed = 0;
          if (pd) exp_wake = 1'b1;
          else    exp_reset = 1'b1;
        end
      end
    end
  end

  task automatic check(input logic act, input logic exp, input string what);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(wdt_reset, exp_reset, "reset out");
      check(wdt_wake, exp_wake, "wake out");
      if (wdt_reset === 1'b1) n_reset++;
      if (wdt_wake === 1'b1)  n_wake++;
    end
  endtask

  task automatic count_check(input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    req = "R1";
    cyc(3);
    rst = 1'b0;
    en  = 1'b1;
    cyc(1);

    // R2: factor 8, 40 ticks per timeout, two timeouts in 85 cycles
    req = "R2"; ps_assign = 1'b1; ps_sel = 3'd3;
    n_reset = 0; cyc(84);
    count_check(n_reset, 2, "pulse count factor 8");
    // R2: largest factor 128 -> 640 ticks
    clr = 1'b1; cyc(1); clr = 1'b0;
    ps_sel = 3'd7; n_reset = 0;
    cyc(639); count_check(n_reset, 0, "no pulse before 640 ticks");
    cyc(1);   count_check(n_reset, 1, "pulse at tick 640");
    // R6: periodic with factor 1
    req = "R6"; ps_sel = 3'd0; n_reset = 0;
    cyc(30); count_check(n_reset, 6, "repeat every base interval");
    // R3: unassigned prescaler ignores select
    req = "R3"; ps_assign = 1'b0; ps_sel = 3'd7;
    clr = 1'b1; cyc(1); clr = 1'b0; n_reset = 0;
    cyc(20); count_check(n_reset, 4, "factor 1 when unassigned");
    // R4: reset pulse only with pd low
    req = "R4"; ps_assign = 1'b1; ps_sel = 3'd1; n_wake = 0; n_reset = 0;
    cyc(25); count_check(n_wake, 0, "no wake while running");
    // R5: wakeup while powered down
    req = "R5"; pd = 1'b1; n_wake = 0; n_reset = 0;
    cyc(40); count_check(n_reset, 0, "no reset while asleep");
    count_check(n_wake, 4, "wake pulses");
    pd = 1'b0;
    // R7: clears every 8 ticks keep a 10-tick watchdog quiet
    req = "R7"; clr = 1'b1; cyc(1); clr = 1'b0; n_reset = 0;
    for (int k = 0; k < 8; k++) begin
      cyc(7); clr = 1'b1; cyc(1); clr = 1'b0;
    end
    count_check(n_reset, 0, "periodic clear");
    // R7: clear exactly on expiring tick
    cyc(9); clr = 1'b1; cyc(1); clr = 1'b0;
    count_check(n_reset, 0, "clear on expiring tick");
    cyc(10); count_check(n_reset, 1, "full interval after clear");
    // R8: disabled freezes count and ignores clear
    req = "R8"; cyc(4); en = 1'b0; n_reset = 0;
    for (int k = 0; k < 5; k++) begin
      clr = 1'b1; cyc(1); clr = 1'b0; cyc(3);
    end
    count_check(n_reset, 0, "quiet while disabled");
    en = 1'b1; cyc(6); count_check(n_reset, 1, "resume from held count");
    // R9: lower factor after several intervals done
    req = "R9"; clr = 1'b1; cyc(1); clr = 1'b0;
    ps_sel = 3'd6; n_reset = 0; cyc(22);
    ps_sel = 3'd2; cyc(3); count_check(n_reset, 1, "fire at next boundary");
    cyc(20); count_check(n_reset, 2, "new factor afterwards");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog %s: actual hung expected finished", req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule